// File: doc/BRIEF.md
# Multi-port hardware mutex bank

This block holds a small bank of mutex slots that several processor ports share. Processors that have no atomic instructions use it to get a test-and-set that cannot be interleaved. A port presents an operation, a slot index, its own processor identifier and, optionally, a 32-bit data word such as the address being guarded. The bank performs the whole read-modify-write of the slot in one cycle. It returns a one-cycle response pulse with a success flag, an error flag and the state of the slot after the operation: the taken flag, the owner identifier and the data word.

At most one request is carried out per cycle. When several ports ask at once, the lowest-numbered port goes first and the others follow in index order on the next cycles. Each later request therefore sees the effect of the earlier ones. Software that shares a single port among several requesters must keep them apart itself; the bank only separates ports. The number of slots and ports is set by parameters, and the data word can be left out of the build (`HAS_DATA`).

Top module: `mutex_bank`

## Requirements
- R1: After reset no response is pending, and every slot reads as free with owner 0 and data word 0.
- R2: Operation code 0 (acquire) on a free slot succeeds. It sets the taken flag and stores the requester identifier and the request data word.
- R3: Acquire (code 0) on a slot held by another identifier fails and changes nothing. Acquire by the current owner succeeds and replaces the stored data word.
- R4: Operation code 1 (single attempt) on a free slot succeeds as in R2. On any held slot it fails and changes nothing, even when the requester already owns the slot.
- R5: Operation code 2 (release) by the current owner succeeds. It clears the taken flag, sets the owner to 0 and keeps the data word.
- R6: Release (code 2) by a non-owner, or on a free slot, is ignored: the slot is unchanged, the success flag is 0 and the error flag is 1.
- R7: Operation code 3 (inspect) succeeds, changes nothing and reports the current state of the slot.
- R8: A request accepted at a clock edge is answered by `resp_valid[p]` high for exactly the next cycle. At most one bit of `resp_valid` is set in any cycle, and the shared result outputs belong to that port. Port p uses bits [p*W +: W] of each packed request input, where W is that field's width.
- R9: Requests pending together are served in ascending port index, one per cycle on consecutive cycles. Each one sees the slot state left by the one before.
- R10: A port is not served in the cycle its response is shown. If it keeps `req_valid` high after that cycle, this counts as a new request, answered two cycles after the previous response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORTS | Request pending, one bit per port |
| req_op | input | 2*NPORTS | Operation code per port (0 acquire, 1 single attempt, 2 release, 3 inspect) |
| req_slot | input | NPORTS*SLOT_W | Slot index per port |
| req_id | input | NPORTS*8 | Processor identifier per port |
| req_data | input | NPORTS*32 | Data word stored on a successful acquire |
| resp_valid | output | NPORTS | One-cycle response pulse, at most one bit set |
| resp_ok | output | 1 | Operation succeeded |
| resp_err | output | 1 | Release refused (not owner, or slot free) |
| resp_held | output | 1 | Taken flag of the slot after the operation |
| resp_owner | output | 8 | Owner identifier after the operation |
| resp_data | output | 32 | Data word of the slot after the operation |

## Verification
A lone request raised before edge k is answered in the cycle after edge k. When n ports raise requests together, the i-th lowest of them is answered exactly i cycles after they were raised. The bench drives and samples on falling edges. On each falling edge it expects the response bit of the one port that a serial, lowest-index-first reference model names. It checks the result outputs against that model in the same cycle, then drops that port's request. A held request is checked for its quiet cycle and for the repeat response two cycles later.

// File: rtl/mb_pkg.sv
package mb_pkg;

    localparam int MB_ID_W   = 8;
    localparam int MB_DATA_W = 32;

    typedef enum logic [1:0] {
        OP_ACQUIRE = 2'd0,
        OP_ATTEMPT = 2'd1,
        OP_RELEASE = 2'd2,
        OP_INSPECT = 2'd3
    } mb_op_e;

    typedef struct packed {
        logic                 held;
        logic [MB_ID_W-1:0]   owner;
        logic [MB_DATA_W-1:0] word;
    } slot_t;

    typedef struct packed {
        slot_t nxt;
        logic  ok;
        logic  err;
    } step_t;

    // One atomic read-modify-write of a slot.
    function automatic step_t mb_step(slot_t cur, mb_op_e op,
                                      logic [MB_ID_W-1:0] who,
                                      logic [MB_DATA_W-1:0] word);
        step_t st;
        st.nxt = cur;
        st.ok  = 1'b0;
        st.err = 1'b0;
        unique case (op)
            OP_ACQUIRE: begin
                if (!cur.held) begin
                    st.nxt = '{held: 1'b1, owner: who, word: word};
                    st.ok  = 1'b1;
                end else if (cur.owner == who) begin
                    st.nxt.word = word;
                    st.ok       = 1'b1;
                end
            end
            OP_ATTEMPT: begin
                if (!cur.held) begin
                    st.nxt = '{held: 1'b1, owner: who, word: word};
                    st.ok  = 1'b1;
                end
            end
            OP_RELEASE: begin
                if (cur.held && cur.owner == who) begin
                    st.nxt.held  = 1'b0;
                    st.nxt.owner = '0;
                    st.ok        = 1'b1;
                end else begin
                    st.err = 1'b1;
                end
            end
            default: st.ok = 1'b1;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/mb_arbiter.sv
module mb_arbiter #(
    parameter int NPORTS = 4,
    parameter int PIDX_W = 2
) (
    input  logic [NPORTS-1:0] req,
    input  logic [NPORTS-1:0] mask,
    output logic [NPORTS-1:0] gnt,
    output logic              any,
    output logic [PIDX_W-1:0] idx
);
    // Descending scan: the lowest eligible index is assigned last and wins.
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (req[i] && !mask[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = PIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mb_slot_file.sv
module mb_slot_file
    import mb_pkg::*;
#(
    parameter int NSLOTS = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] addr,
    input  slot_t             wdata,
    output slot_t             rdata
);
    slot_t cells [NSLOTS];

    for (genvar s = 0; s < NSLOTS; s++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[s] <= '0;
            else if (we && addr == SLOT_W'(s))
                cells[s] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < NSLOTS)
            rdata = cells[addr];
    end
endmodule

// File: rtl/mb_engine.sv
module mb_engine
    import mb_pkg::*;
#(
    parameter int NPORTS   = 4,
    parameter int NSLOTS   = 8,
    parameter int SLOT_W   = 3,
    parameter int PIDX_W   = 2,
    parameter int HAS_DATA = 1
) (
    input  logic                          any,
    input  logic [PIDX_W-1:0]             sel,
    input  logic [2*NPORTS-1:0]           req_op,
    input  logic [NPORTS*SLOT_W-1:0]      req_slot,
    input  logic [NPORTS*MB_ID_W-1:0]     req_id,
    input  logic [NPORTS*MB_DATA_W-1:0]   req_data,
    input  slot_t                         cur,
    output logic [SLOT_W-1:0]             slot_idx,
    output logic                          write,
    output slot_t                         nxt,
    output logic                          ok,
    output logic                          err
);
    mb_op_e               op;
    logic [MB_ID_W-1:0]   who;
    logic [MB_DATA_W-1:0] word;
    logic                 in_range;
    step_t                st;

    always_comb begin
        op       = mb_op_e'(req_op[int'(sel)*2 +: 2]);
        slot_idx = req_slot[int'(sel)*SLOT_W +: SLOT_W];
        who      = req_id[int'(sel)*MB_ID_W +: MB_ID_W];
        word     = req_data[int'(sel)*MB_DATA_W +: MB_DATA_W];
        in_range = int'(slot_idx) < NSLOTS;
        st       = mb_step(cur, op, who, word);
    end

    for (genvar g = 0; g < 1; g++) begin : g_word
        if (HAS_DATA != 0) begin : g_keep
            assign nxt = in_range ? st.nxt : cur;
        end else begin : g_drop
            slot_t trimmed;
            always_comb begin
                trimmed      = in_range ? st.nxt : cur;
                trimmed.word = '0;
            end
            assign nxt = trimmed;
        end
    end

    assign write = any && in_range;
    assign ok    = in_range && st.ok;
    assign err   = !in_range || st.err;
endmodule

// File: rtl/mutex_bank.sv
module mutex_bank
    import mb_pkg::*;
#(
    parameter  int NPORTS   = 4,
    parameter  int NSLOTS   = 8,
    parameter  int HAS_DATA = 1,
    localparam int SLOT_W   = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
    localparam int PIDX_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORTS-1:0]            req_valid,
    input  logic [2*NPORTS-1:0]          req_op,
    input  logic [NPORTS*SLOT_W-1:0]     req_slot,
    input  logic [NPORTS*MB_ID_W-1:0]    req_id,
    input  logic [NPORTS*MB_DATA_W-1:0]  req_data,
    output logic [NPORTS-1:0]            resp_valid,
    output logic                         resp_ok,
    output logic                         resp_err,
    output logic                         resp_held,
    output logic [MB_ID_W-1:0]           resp_owner,
    output logic [MB_DATA_W-1:0]         resp_data
);
    logic [NPORTS-1:0] gnt;
    logic              any;
    logic [PIDX_W-1:0] sel;
    logic [SLOT_W-1:0] slot_idx;
    logic              write;
    logic              ok;
    logic              err;
    slot_t             cur;
    slot_t             nxt;

    // A port whose answer is on the outputs this cycle sits out one cycle.
    mb_arbiter #(.NPORTS(NPORTS), .PIDX_W(PIDX_W)) u_arb (
        .req  (req_valid),
        .mask (resp_valid),
        .gnt  (gnt),
        .any  (any),
        .idx  (sel)
    );

    mb_engine #(
        .NPORTS(NPORTS), .NSLOTS(NSLOTS), .SLOT_W(SLOT_W),
        .PIDX_W(PIDX_W), .HAS_DATA(HAS_DATA)
    ) u_eng (
        .any      (any),
        .sel      (sel),
        .req_op   (req_op),
        .req_slot (req_slot),
        .req_id   (req_id),
        .req_data (req_data),
        .cur      (cur),
        .slot_idx (slot_idx),
        .write    (write),
        .nxt      (nxt),
        .ok       (ok),
        .err      (err)
    );

    mb_slot_file #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_file (
        .clk   (clk),
        .rst   (rst),
        .we    (write),
        .addr  (slot_idx),
        .wdata (nxt),
        .rdata (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= '0;
            resp_ok    <= 1'b0;
            resp_err   <= 1'b0;
            resp_held  <= 1'b0;
            resp_owner <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= gnt;
            if (any) begin
                resp_ok    <= ok;
                resp_err   <= err;
                resp_held  <= nxt.held;
                resp_owner <= nxt.owner;
                resp_data  <= nxt.word;
            end
        end
    end
endmodule

// File: rtl/mb_checker.sv
module mb_checker
    import mb_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [NPORTS-1:0]   req_valid,
    input logic [NPORTS-1:0]   resp_valid,
    input logic                resp_ok,
    input logic                resp_err,
    input logic                resp_held,
    input logic [MB_ID_W-1:0]  resp_owner
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> resp_valid == '0);

    assert_free_no_owner_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid != '0 && !resp_held) |-> resp_owner == '0);

    assert_refused_not_ok_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid != '0 && resp_err) |-> !resp_ok);

    assert_single_resp_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resp_valid));

    assert_resp_had_req_R8: assert property (@(posedge clk) disable iff (rst)
        resp_valid != '0 |-> ((($past(req_valid) & resp_valid)) == resp_valid));

    assert_port0_first_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid[0] && !resp_valid[0]) |=> resp_valid[0]);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assert_gap_after_resp_R10: assert property (@(posedge clk) disable iff (rst)
            resp_valid[p] |=> !resp_valid[p]);
    end
endmodule

bind mutex_bank mb_checker #(.NPORTS(NPORTS)) u_mb_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .resp_valid (resp_valid),
    .resp_ok    (resp_ok),
    .resp_err   (resp_err),
    .resp_held  (resp_held),
    .resp_owner (resp_owner)
);

// File: tb/mutex_bank_bench.sv
module mutex_bank_bench;
    localparam int NP = 4;
    localparam int NS = 8;
    localparam int SW = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NP-1:0]      req_valid = '0;
    logic [2*NP-1:0]    req_op = '0;
    logic [NP*SW-1:0]   req_slot = '0;
    logic [NP*8-1:0]    req_id = '0;
    logic [NP*32-1:0]   req_data = '0;
    logic [NP-1:0]      resp_valid;
    logic               resp_ok, resp_err, resp_held;
    logic [7:0]         resp_owner;
    logic [31:0]        resp_data;

    mutex_bank #(.NPORTS(NP), .NSLOTS(NS), .HAS_DATA(1)) u_mutex_bank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_slot(req_slot), .req_id(req_id), .req_data(req_data),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_err(resp_err),
        .resp_held(resp_held), .resp_owner(resp_owner), .resp_data(resp_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    bit        m_held  [NS];
    bit [7:0]  m_owner [NS];
    bit [31:0] m_word  [NS];

    // Per-port request description for one round
    int        r_op   [NP];
    int        r_slot [NP];
    bit [7:0]  r_id   [NP];
    bit [31:0] r_dat  [NP];

    task automatic check(input bit good, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input int op, input int s, input bit [7:0] id,
                         input bit [31:0] d, output bit ok, output bit err,
                         output string tag);
        ok = 0; err = 0;
        case (op)
            0: begin
                if (!m_held[s]) begin
                    m_held[s] = 1; m_owner[s] = id; m_word[s] = d; ok = 1; tag = "R2";
                end else if (m_owner[s] == id) begin
                    m_word[s] = d; ok = 1; tag = "R3";
                end else tag = "R3";
            end
            1: begin
                tag = "R4";
                if (!m_held[s]) begin
                    m_held[s] = 1; m_owner[s] = id; m_word[s] = d; ok = 1;
                end
            end
            2: begin
                if (m_held[s] && m_owner[s] == id) begin
                    m_held[s] = 0; m_owner[s] = 0; ok = 1; tag = "R5";
                end else begin
                    err = 1; tag = "R6";
                end
            end
            default: begin ok = 1; tag = "R7"; end
        endcase
    endtask

    task automatic drive_port(input int p);
        req_op[p*2 +: 2]    = 2'(r_op[p]);
        req_slot[p*SW +: SW] = SW'(r_slot[p]);
        req_id[p*8 +: 8]    = r_id[p];
        req_data[p*32 +: 32] = r_dat[p];
    endtask

    task automatic check_result(input int p, input string tag, input bit ok, input bit err,
                                input int s);
        check(resp_valid == NP'(1 << p), "R8", "resp_valid", 64'(resp_valid), 64'(1 << p));
        check(resp_ok == ok, tag, "ok", 64'(resp_ok), 64'(ok));
        check(resp_err == err, tag, "err", 64'(resp_err), 64'(err));
        check(resp_held == m_held[s], tag, "held", 64'(resp_held), 64'(m_held[s]));
        check(resp_owner == m_owner[s], tag, "owner", 64'(resp_owner), 64'(m_owner[s]));
        check(resp_data == m_word[s], tag, "data", 64'(resp_data), 64'(m_word[s]));
    endtask

    // Raise all ports in mask together; expect service lowest index first,
    // one port per cycle (R9), each answered on the next falling edge (R8).
    task automatic run_round(input bit [NP-1:0] mask);
        bit [NP-1:0] pending = mask;
        @(negedge clk);
        for (int p = 0; p < NP; p++) if (mask[p]) drive_port(p);
        req_valid = mask;
        while (pending != 0) begin
            int  p = 0;
            bit  ok, err;
            string tag;
            while (!pending[p]) p++;
            @(negedge clk);
            model(r_op[p], r_slot[p], r_id[p], r_dat[p], ok, err, tag);
            if ($countones(mask) > 1 && resp_valid != NP'(1 << p))
                check(0, "R9", "service order", 64'(resp_valid), 64'(1 << p));
            check_result(p, tag, ok, err, r_slot[p]);
            req_valid[p] = 1'b0;
            pending[p] = 1'b0;
        end
        @(negedge clk);
        check(resp_valid == '0, "R8", "idle after round", 64'(resp_valid), 64'd0);
    endtask

    task automatic single(input int p, input int op, input int s, input bit [7:0] id,
                          input bit [31:0] d);
        r_op[p] = op; r_slot[p] = s; r_id[p] = id; r_dat[p] = d;
        run_round(NP'(1 << p));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int s = 0; s < NS; s++) begin m_held[s] = 0; m_owner[s] = 0; m_word[s] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(resp_valid == '0, "R1", "resp_valid after reset", 64'(resp_valid), 64'd0);

        // R1: every slot free, owner 0, data 0
        for (int s = 0; s < NS; s++) single(0, 3, s, 8'h11, 32'h0);

        // R2 grant, R3 foreign refused, R3 owner refresh
        single(0, 0, 2, 8'h21, 32'hA000_0002);
        single(1, 0, 2, 8'h33, 32'hDEAD_BEEF);
        single(2, 0, 2, 8'h21, 32'hB000_0002);
        // R4: attempt on held slot by owner fails; on free slot succeeds
        single(3, 1, 2, 8'h21, 32'h1234_5678);
        single(3, 1, 5, 8'h44, 32'h5555_0005);
        // R6: release by stranger and on free slot
        single(1, 2, 2, 8'h33, 32'h0);
        single(1, 2, 6, 8'h33, 32'h0);
        // R5: release by owner keeps data
        single(0, 2, 2, 8'h21, 32'h0);
        // R7: inspect
        single(2, 3, 2, 8'h99, 32'h0);
        single(2, 3, 5, 8'h99, 32'h0);

        // R9: all four race for slot 7 with distinct ids
        for (int p = 0; p < NP; p++) begin
            r_op[p] = 0; r_slot[p] = 7; r_id[p] = 8'(8'h60 + p); r_dat[p] = 32'(p + 100);
        end
        run_round(4'b1111);
        // R9: ports 1 and 3 - release by owner? owner is 0x60, both refused
        r_op[1] = 2; r_slot[1] = 7; r_id[1] = 8'h61;
        r_op[3] = 1; r_slot[3] = 7; r_id[3] = 8'h63; r_dat[3] = 32'h77;
        run_round(4'b1010);

        // R10: held request on port 1 is served, skipped one cycle, served again
        r_op[1] = 0; r_slot[1] = 4; r_id[1] = 8'h71; r_dat[1] = 32'hCAFE_0004;
        @(negedge clk);
        drive_port(1);
        req_valid = 4'b0010;
        begin
            bit ok, err; string tag;
            @(negedge clk);
            model(0, 4, 8'h71, 32'hCAFE_0004, ok, err, tag);
            check_result(1, "R10", ok, err, 4);
            @(negedge clk);
            check(resp_valid == '0, "R10", "masked cycle", 64'(resp_valid), 64'd0);
            @(negedge clk);
            model(0, 4, 8'h71, 32'hCAFE_0004, ok, err, tag);
            check_result(1, "R10", ok, err, 4);
            req_valid = '0;
            @(negedge clk);
            check(resp_valid == '0, "R10", "after drop", 64'(resp_valid), 64'd0);
        end

        // Random rounds on a narrow set of slots and ids to force contention
        for (int n = 0; n < 400; n++) begin
            bit [NP-1:0] mask;
            mask = NP'($urandom_range(1, (1 << NP) - 1));
            for (int p = 0; p < NP; p++) begin
                r_op[p]   = $urandom_range(0, 3);
                r_slot[p] = ($urandom_range(0, 3) == 0) ? $urandom_range(0, NS - 1)
                                                        : $urandom_range(0, 2);
                r_id[p]   = 8'($urandom_range(1, 4));
                r_dat[p]  = $urandom;
            end
            run_round(mask);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule